// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counting timer. It advances on a clock enable that runs at one quarter of the system clock, and that enable is first divided by a selectable prescaler. The count is compared with a programmable period value. When the two are equal, the next prescaled tick returns the count to zero instead of incrementing it. That wrap produces a one-cycle unscaled pulse, which PWM or serial-clock logic beside the timer can use as a time base.

A 4-bit postscaler counts wraps. It sets a sticky interrupt flag on every (n+1)th wrap, where n is the postscaler field. The flag stays set until software clears it. The interrupt request is the flag gated by an enable input.

Software programs the block through a single-cycle write port that reaches the control, counter and period registers. A registered read port returns those registers.

Top module: `match_timer`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0 and the period register reads 0xFF. `irq_flag`, `irq` and `match_pulse` are all 0.
- R2: The timer advances once per prescaled tick while control bit 2 (run) is 1. A prescaled tick occurs once every 4·P system clocks. P is set by control bits 1:0: 00 gives P=1, 01 gives P=4, and 10 or 11 gives P=16.
- R3: The counter runs from 0 up to the period value. On the tick that finds it equal to the period value, it returns to 0, so one period lasts period+1 ticks. `match_pulse` is high for exactly one clock, in the cycle where the counter first reads 0 after that wrap.
- R4: A counter written above the period value keeps counting up, passes from 255 to 0 without a match, and then matches normally.
- R5: While run is 0 the counter holds its value and no `match_pulse` occurs.
- R6: With control bits 6:3 equal to n, `irq_flag` is set together with every (n+1)th `match_pulse`, for n from 0 to 15.
- R7: `irq_flag` stays set until a clock in which `flag_clr` is 1. If a flag-setting match falls in the same clock as `flag_clr`, the set takes precedence.
- R8: `irq` is 1 exactly when `irq_flag` is 1 and `irq_en` is 1.
- R9: With `wr_en` high, `wr_sel` 0 writes control, 1 writes the counter and 2 writes the period. A control or counter write restarts the prescaler and postscaler counts and suppresses any tick in that clock. Control bit 7 is not stored and reads as 0.
- R10: `rd_data` is registered. It shows the register chosen by `rd_sel` (0 control, 1 counter, 2 period), as it stood before the last clock edge. `rd_sel` 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 counter, 2 period |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read source: 0 control, 1 counter, 2 period, 3 zero |
| rd_data | output | 8 | Registered read data |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the interrupt flag |
| match_pulse | output | 1 | One-cycle unscaled period-match pulse |
| irq_flag | output | 1 | Sticky postscaled match flag |
| irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
The pulse spacing is measured at each prescaler encoding with the same period, so a wrong ratio or a confused select code shows up as a wrong gap in clocks. Postscaler ratios at both ends of the range (1:1, 1:3, 1:16) are checked by counting pulses up to the flag's rise. A control rewrite halfway through a postscaler count shows whether the write really restarts it. A counter preloaded above the period, a stopped timer and a flag clear held over flag-setting matches separate the overflow, hold and set-over-clear rules. A behavioural model also follows every clock through all of these patterns.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // control field positions
  localparam int PRE_LSB = 0;
  localparam int RUN_BIT = 2;
  localparam int PS_LSB  = 3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CLK_DIV = 4,
  parameter int PRE_MID = 4,
  parameter int PRE_MAX = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int PRE_W = $clog2(PRE_MAX);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             q_tick;

  assign q_tick = (div_q == DIV_W'(CLK_DIV - 1));

  always_comb begin
    case (sel)
      2'b00:   lim = '0;
      2'b01:   lim = PRE_W'(PRE_MID - 1);
      default: lim = PRE_W'(PRE_MAX - 1);
    endcase
  end

  assign tick = q_tick && run && !clr && (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= q_tick ? '0 : div_q + DIV_W'(1);
      if (clr)
        pre_q <= '0;
      else if (q_tick && run)
        pre_q <= (pre_q == lim) ? '0 : pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  assign match = tick && (cnt == period);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (tick)
      cnt <= match ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/tmr_post.sv
module tmr_post #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            match,
  input  logic            clr,
  input  logic [PS_W-1:0] ratio,
  input  logic            flag_clr,
  output logic            flag
);
  logic [PS_W-1:0] post_q;
  logic            hit;

  assign hit = match && (post_q == ratio);

  always_ff @(posedge clk) begin
    if (rst) begin
      post_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (clr)
        post_q <= '0;
      else if (match)
        post_q <= hit ? '0 : post_q + PS_W'(1);
      if (hit)
        flag <= 1'b1;
      else if (flag_clr)
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PS_W    = 4,
  parameter int CLK_DIV = 4,
  parameter int PRE_MID = 4,
  parameter int PRE_MAX = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             match_pulse,
  output logic             irq_flag,
  output logic             irq
);
  localparam int CTRL_W = PS_LSB + PS_W;

  reg_sel_e         wsel, rsel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  period_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ctrl_wr, cnt_load, restart, tick, match;

  assign wsel     = reg_sel_e'(wr_sel);
  assign rsel     = reg_sel_e'(rd_sel);
  assign ctrl_wr  = wr_en && (wsel == SEL_CTRL);
  assign cnt_load = wr_en && (wsel == SEL_COUNT);
  assign restart  = ctrl_wr || cnt_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (ctrl_wr)
        ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_en && (wsel == SEL_PERIOD))
        period_q <= wr_data;
    end
  end

  tmr_prescale #(
    .CLK_DIV(CLK_DIV), .PRE_MID(PRE_MID), .PRE_MAX(PRE_MAX)
  ) u_pre (
    .clk(clk), .rst(rst), .run(ctrl_q[RUN_BIT]), .clr(restart),
    .sel(ctrl_q[PRE_LSB +: 2]), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_load),
    .load_val(wr_data), .period(period_q), .cnt(cnt_q), .match(match)
  );

  tmr_post #(.PS_W(PS_W)) u_post (
    .clk(clk), .rst(rst), .match(match), .clr(restart),
    .ratio(ctrl_q[PS_LSB +: PS_W]), .flag_clr(flag_clr), .flag(irq_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_pulse <= 1'b0;
      rd_data     <= '0;
    end else begin
      match_pulse <= match;
      case (rsel)
        SEL_CTRL:   rd_data <= CNT_W'(ctrl_q);
        SEL_COUNT:  rd_data <= cnt_q;
        SEL_PERIOD: rd_data <= period_q;
        default:    rd_data <= '0;
      endcase
    end
  end

  assign irq = irq_flag && irq_en;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             match_pulse,
  input logic             irq_flag,
  input logic             flag_clr,
  input logic             run,
  input logic             cnt_load,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       rd_sel,
  input logic [CNT_W-1:0] rd_data
);
  // R3: the pulse never lasts two clocks
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> !match_pulse);

  // R3: the pulse coincides with the counter at zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> (cnt == '0));

  // R5: a stopped timer holds its count
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(cnt_load)) |-> $stable(cnt));

  // R6: the flag only rises together with a match pulse
  a_r6_rise_on_match: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> match_pulse);

  // R7: the flag only falls after a clear request
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_flag) |-> $past(flag_clr));

  // R9: control bit 7 reads as zero
  a_r9_bit7_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) == 2'd0) |-> !rd_data[7]);

  // R10: the unused read select returns zero
  a_r10_none_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) == 2'd3) |-> (rd_data == '0));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .match_pulse(match_pulse), .irq_flag(irq_flag),
  .flag_clr(flag_clr), .run(ctrl_q[2]), .cnt_load(cnt_load), .cnt(cnt_q),
  .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       irq_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       match_pulse, irq_flag, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  match_timer i_match_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_en(irq_en), .flag_clr(flag_clr),
    .match_pulse(match_pulse), .irq_flag(irq_flag), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_div = 0, m_pre = 0, m_cnt = 0, m_pr = 255, m_ctrl = 0, m_post = 0;
  int m_rd = 0;
  bit m_flag = 0, m_pulse = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_pre = 0; m_cnt = 0; m_pr = 255; m_ctrl = 0; m_post = 0;
      m_rd = 0; m_flag = 0; m_pulse = 0;
    end else begin
      int ratio, ps, nrd;
      bit run, qt, restart, tk, mt, hit;
      ratio = ((m_ctrl & 3) == 0) ? 1 : ((m_ctrl & 3) == 1) ? 4 : 16;
      run   = (m_ctrl >> 2) & 1;
      ps    = (m_ctrl >> 3) & 15;
      qt    = (m_div == 3);
      restart = wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1);
      tk    = qt && run && !restart && (m_pre == ratio - 1);
      mt    = tk && (m_cnt == m_pr);
      hit   = mt && (m_post == ps);
      case (rd_sel)
        2'd0: nrd = m_ctrl;
        2'd1: nrd = m_cnt;
        2'd2: nrd = m_pr;
        default: nrd = 0;
      endcase
      m_rd  = nrd;
      m_div = (m_div + 1) % 4;
      if (restart) m_pre = 0;
      else if (qt && run) m_pre = (m_pre == ratio - 1) ? 0 : m_pre + 1;
      if (wr_en && wr_sel == 2'd1) m_cnt = wr_data;
      else if (tk) m_cnt = mt ? 0 : (m_cnt + 1) % 256;
      if (restart) m_post = 0;
      else if (mt) m_post = hit ? 0 : m_post + 1;
      if (hit) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_pulse = mt;
      if (wr_en && wr_sel == 2'd0) m_ctrl = wr_data & 8'h7F;
      if (wr_en && wr_sel == 2'd2) m_pr = wr_data;
    end
  end

  // per-cycle comparison, away from the active edge
  int cyc = 0, last_pulse = 0, gap = 0, pcount = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    check(match_pulse == m_pulse, "R3 match_pulse", match_pulse, m_pulse);
    check(irq_flag == m_flag, "R7 irq_flag", irq_flag, m_flag);
    check(irq == (m_flag && irq_en), "R8 irq", irq, m_flag && irq_en);
    check(rd_data == m_rd[7:0], "R10 rd_data", rd_data, m_rd);
    if (match_pulse) begin
      gap = cyc - last_pulse;
      last_pulse = cyc;
      pcount++;
    end
  end

  // ---------------- stimulus helpers (start just after a posedge) ----------------
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    rd_sel = sel;
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; idle(1); flag_clr = 1'b0;
  endtask

  // waits for the flag and returns the number of pulses seen up to it
  task automatic wait_flag(output int seen);
    int guard = 0;
    while (!irq_flag && guard < 5000) begin idle(1); guard++; end
    #5;
    seen = pcount;
    @(posedge clk); #1;
  endtask

  int v, v2, seen;

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset values
    check(match_pulse == 0 && irq_flag == 0 && irq == 0, "R1 outputs", irq_flag, 0);
    rd(2'd0, v); check(v == 0, "R1 ctrl reset", v, 0);
    rd(2'd1, v); check(v == 0, "R1 count reset", v, 0);
    rd(2'd2, v); check(v == 255, "R1 period reset", v, 255);

    // R2/R3: pulse gap = 4*P*(period+1)
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h05);                 // run, prescale 1:4
    idle(300); check(gap == 96, "R2 R3 gap 1:4", gap, 96);
    wr(2'd0, 8'h07);                 // run, prescale code 11 -> 1:16
    idle(900); check(gap == 384, "R2 gap 1:16", gap, 384);
    wr(2'd0, 8'h04);                 // run, prescale 1:1
    idle(100); check(gap == 24, "R2 gap 1:1", gap, 24);

    // R6: postscaler 1:3, period 1
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h14);
    clear_flag(); pcount = 0;
    wait_flag(seen); check(seen == 3, "R6 postscale 1:3", seen, 3);
    irq_en = 1'b1; idle(1);
    check(irq == 1, "R8 irq when enabled", irq, 1);
    irq_en = 1'b0;

    // R6: postscaler 1:16, period 0
    wr(2'd2, 8'd0);
    wr(2'd0, 8'h7C);
    clear_flag(); pcount = 0;
    wait_flag(seen); check(seen == 16, "R6 postscale 1:16", seen, 16);

    // R7: flag stays with the timer stopped, then clears
    wr(2'd0, 8'h00);
    idle(20); check(irq_flag == 1, "R7 sticky", irq_flag, 1);
    clear_flag(); check(irq_flag == 0, "R7 cleared", irq_flag, 0);

    // R7: set wins over a clear held through matches (1:1 postscale)
    wr(2'd0, 8'h04);
    flag_clr = 1'b1;
    seen = 0;
    repeat (40) begin idle(1); if (irq_flag) seen++; end
    flag_clr = 1'b0;
    check(seen > 0, "R7 set over clear", seen, 1);
    clear_flag();

    // R9: control rewrite restarts the postscaler (ratio 1:2)
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h0C);
    clear_flag(); pcount = 0;
    while (pcount == 0) idle(1);
    wr(2'd0, 8'h0C);
    pcount = 0;
    wait_flag(seen); check(seen == 2, "R9 restart postscaler", seen, 2);

    // R5: stopped timer holds the counter
    wr(2'd2, 8'd200);
    wr(2'd0, 8'h04);
    idle(37);
    wr(2'd0, 8'h00);
    rd(2'd1, v); pcount = 0;
    idle(50);
    rd(2'd1, v2);
    check(v == v2, "R5 hold", v2, v);
    check(pcount == 0, "R5 no pulse", pcount, 0);

    // R4: counter above period wraps through 255 without a match
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'd250);
    pcount = 0;
    idle(21); check(pcount == 0, "R4 no match above period", pcount, 0);
    idle(38); check(pcount == 1, "R4 match after wrap", pcount, 1);

    // R9/R10: bit 7 not stored, select 3 reads zero
    wr(2'd0, 8'hFF);
    rd(2'd0, v); check(v == 8'h7F, "R9 ctrl bit7", v, 8'h7F);
    rd(2'd3, v); check(v == 0, "R10 select 3", v, 0);
    wr(2'd0, 8'h80);
    rd(2'd0, v); check(v == 0, "R9 bit7 only", v, 0);
    idle(5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule